// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes received Ethernet frames from a MAC as a byte stream and stores them in a circular buffer in local packet memory. The memory is split into pages of 2^OFF_W bytes (256 by default). The ring covers the pages from a start page up to, but not including, a stop page. A host programs four page registers over a small register port. Two of them set the ring limits. The third is the current page, where the next frame will be written. The fourth is the boundary, which is one below the oldest page the host has not yet consumed. The ring is empty when the current page equals the boundary plus one, with wrap taken into account.

Each frame's bytes are written starting four bytes into the current page. Writing runs through consecutive addresses and wraps from the stop page back to the start page, so a frame may straddle the wrap point. Once the last byte has arrived, a good frame receives a four-byte header at the start of its first page, and the current page moves past the frame. A frame with a CRC or alignment error, or one that would run into the boundary page, is discarded. Every frame ends with a one-cycle status report.

The input stream is valid/ready. A beat transfers on a clock edge where `in_valid` and `in_ready` are both high. The MAC may insert idle cycles at any point. While `in_ready` is low, the MAC must hold its beat. `in_ready` is low only during the four header-write cycles that follow the last beat of a good frame.

Top module: `rxr_ring_writer`

## Requirements
- R1: Host register port: address 0 is the ring start page, 1 the ring stop page, 2 the current page, 3 the boundary. A register is written at the clock edge where `reg_we` is high. `reg_rdata` shows the addressed register combinationally. All four registers reset to 0.
- R2: The first byte of a frame is written at offset 4 of the current page. Each following byte goes to the next offset. After the last offset of a page, writing continues at offset 0 of the next page, where the page after stop-1 is the start page.
- R3: For a good frame, the four cycles after its last beat write the header at offsets 0 to 3 of the frame's first page: byte 0 is status 0x01, byte 1 is the next-page value, bytes 2 and 3 are the length, low byte first.
- R4: The stored length is the number of beats in the frame, including the four trailing CRC bytes the MAC passes through.
- R5: After a good frame, the current page becomes the page that follows the page holding the frame's last byte, wrapped. This is the same value as header byte 1. The current page changes in no other way except by a host write.
- R6: `stat_code` bit 0 (0x01) marks a good frame, bit 1 (0x02) a CRC error (`in_err[0]` on the last beat), bit 2 (0x04) an alignment error (`in_err[1]` on the last beat), and bit 3 (0x08) an overflow. An errored frame gets no header and leaves the current page unchanged.
- R7: A byte whose page equals the boundary is never written. The rest of that frame is accepted and discarded, the current page is unchanged, and the frame reports status 0x08.
- R8: `stat_valid` pulses for one cycle per frame. For an errored or overflowed frame, it pulses in the cycle after the last beat. For a good frame, it pulses in the cycle after the fourth header write, which is also the first cycle in which the new current page is visible.
- R9: `in_ready` is high except in exactly the four header cycles of a good frame. Idle gaps between beats do not change the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of the frame |
| in_err | input | 2 | Errors on the last beat: bit 0 CRC, bit 1 alignment |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | PAGE_W | Host write data |
| reg_rdata | output | PAGE_W | Addressed register value |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PAGE_W+OFF_W | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| stat_valid | output | 1 | One-cycle per-frame status strobe |
| stat_code | output | 8 | Per-frame status byte |

## Verification
The hardest case to reach is an overflow at an arbitrary point inside a frame, including on its very first byte. It needs the current page to come around to the boundary after the ring has wrapped, and that only happens after many frames with the host deliberately not consuming any. The bench reaches it in two steps. First it runs a long sweep of frame lengths, with the host freeing the ring after every frame, so the write point drifts across the wrap repeatedly. Then it freezes the boundary and sends frames until its arithmetic ring model predicts overflow. It watches the memory port to confirm that the boundary page is never touched, and it checks that the ring recovers once pages are freed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {ST_RX, ST_DROP, ST_HDR} rxr_state_e;

  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 16;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_CRC   = 8'h02;
  localparam logic [7:0] STAT_ALIGN = 8'h04;
  localparam logic [7:0] STAT_OVF   = 8'h08;

  localparam logic [1:0] RA_START = 2'd0;
  localparam logic [1:0] RA_STOP  = 2'd1;
  localparam logic [1:0] RA_CURR  = 2'd2;
  localparam logic [1:0] RA_BOUND = 2'd3;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [PAGE_W-1:0] wdata,
  input  logic              commit,
  input  logic [PAGE_W-1:0] commit_page,
  output logic [PAGE_W-1:0] rdata,
  output logic [PAGE_W-1:0] pstart,
  output logic [PAGE_W-1:0] pstop,
  output logic [PAGE_W-1:0] curr,
  output logic [PAGE_W-1:0] bound
);
  import rxr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstart <= '0;
      pstop  <= '0;
      curr   <= '0;
      bound  <= '0;
    end else begin
      if (we && addr == RA_START) pstart <= wdata;
      if (we && addr == RA_STOP)  pstop  <= wdata;
      if (we && addr == RA_BOUND) bound  <= wdata;
      // a frame commit takes precedence over a host write in the same cycle
      if (commit)                       curr <= commit_page;
      else if (we && addr == RA_CURR)   curr <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      RA_START: rdata = pstart;
      RA_STOP:  rdata = pstop;
      RA_CURR:  rdata = curr;
      default:  rdata = bound;
    endcase
  end
endmodule

// File: rtl/rxr_wptr.sv
module rxr_wptr #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int LEN_W  = 16,
  parameter int HDR    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              last,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] pstart,
  input  logic [PAGE_W-1:0] pstop,
  output logic [PAGE_W-1:0] cur_page,
  output logic [OFF_W-1:0]  cur_off,
  output logic [PAGE_W-1:0] next_page,
  output logic [PAGE_W-1:0] frame_page,
  output logic [LEN_W-1:0]  len
);
  logic              in_frame;
  logic [PAGE_W-1:0] wpage;
  logic [OFF_W-1:0]  woff;
  logic [PAGE_W-1:0] inc_page;

  assign cur_page  = in_frame ? wpage : start_pg;
  assign cur_off   = in_frame ? woff  : OFF_W'(HDR);
  assign inc_page  = cur_page + 1'b1;
  assign next_page = (inc_page == pstop) ? pstart : inc_page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      wpage      <= '0;
      woff       <= '0;
      frame_page <= '0;
      len        <= '0;
    end else if (adv) begin
      in_frame <= !last;
      woff     <= cur_off + 1'b1;
      wpage    <= (&cur_off) ? next_page : cur_page;
      if (!in_frame) begin
        frame_page <= start_pg;
        len        <= LEN_W'(1);
      end else begin
        len <= len + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxr_hdr.sv
module rxr_hdr #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic [1:0]        idx,
  input  logic [7:0]        status,
  input  logic [PAGE_W-1:0] link,
  input  logic [LEN_W-1:0]  len,
  output logic [7:0]        hbyte
);
  always_comb begin
    unique case (idx)
      2'd0:    hbyte = status;
      2'd1:    hbyte = 8'(link);
      2'd2:    hbyte = len[7:0];
      default: hbyte = len[15:8];
    endcase
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [1:0]        in_err,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              stat_valid,
  output logic [7:0]        stat_code
);
  import rxr_pkg::*;

  rxr_state_e        state;
  logic [1:0]        hcnt;
  logic [PAGE_W-1:0] link_pg;
  logic [PAGE_W-1:0] pstart, pstop, curr, bound;
  logic [PAGE_W-1:0] cur_page, next_page, frame_page;
  logic [OFF_W-1:0]  cur_off;
  logic [LEN_W-1:0]  len;
  logic [7:0]        hbyte;
  logic              acc, hit, commit;

  assign in_ready = (state != ST_HDR);
  assign acc      = in_valid && in_ready;
  assign hit      = (cur_page == bound);
  assign commit   = (state == ST_HDR) && (hcnt == 2'd3);

  rxr_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .commit(commit), .commit_page(link_pg), .rdata(reg_rdata),
    .pstart(pstart), .pstop(pstop), .curr(curr), .bound(bound)
  );

  rxr_wptr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .HDR(HDR_BYTES)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(acc), .last(in_last), .start_pg(curr),
    .pstart(pstart), .pstop(pstop), .cur_page(cur_page), .cur_off(cur_off),
    .next_page(next_page), .frame_page(frame_page), .len(len)
  );

  rxr_hdr #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_hdr (
    .idx(hcnt), .status(STAT_GOOD), .link(link_pg), .len(len), .hbyte(hbyte)
  );

  always_comb begin
    if (state == ST_HDR) begin
      mem_we    = 1'b1;
      mem_addr  = {frame_page, OFF_W'(hcnt)};
      mem_wdata = hbyte;
    end else begin
      mem_we    = acc && (state == ST_RX) && !hit;
      mem_addr  = {cur_page, cur_off};
      mem_wdata = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RX;
      hcnt       <= '0;
      link_pg    <= '0;
      stat_valid <= 1'b0;
      stat_code  <= '0;
    end else begin
      stat_valid <= 1'b0;
      unique case (state)
        ST_RX: if (acc) begin
          if (hit) begin
            if (in_last) begin
              stat_valid <= 1'b1;
              stat_code  <= STAT_OVF;
            end else begin
              state <= ST_DROP;
            end
          end else if (in_last) begin
            if (in_err != 2'b00) begin
              stat_valid <= 1'b1;
              stat_code  <= {5'b0, in_err, 1'b0};
            end else begin
              state   <= ST_HDR;
              hcnt    <= '0;
              link_pg <= next_page;
            end
          end
        end
        ST_DROP: if (acc && in_last) begin
          state      <= ST_RX;
          stat_valid <= 1'b1;
          stat_code  <= STAT_OVF;
        end
        ST_HDR: begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == 2'd3) begin
            state      <= ST_RX;
            stat_valid <= 1'b1;
            stat_code  <= STAT_GOOD;
          end
        end
        default: state <= ST_RX;
      endcase
    end
  end
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_ready,
  input logic                     reg_we,
  input logic [1:0]               reg_addr,
  input logic                     mem_we,
  input logic [PAGE_W+OFF_W-1:0]  mem_addr,
  input logic                     stat_valid,
  input logic [7:0]               stat_code,
  input logic [PAGE_W-1:0]        curr,
  input logic [PAGE_W-1:0]        bound
);
  assert_bound_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && in_ready) |-> (mem_addr[PAGE_W+OFF_W-1:OFF_W] != bound));

  assert_hdr_offsets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !in_ready) |-> (mem_addr[OFF_W-1:0] < OFF_W'(4)));

  assert_good_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_code[0]) |-> (stat_code[7:1] == 7'd0));

  assert_good_after_hdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_code == 8'h01) |-> $past(!in_ready));

  assert_curr_only_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((curr != $past(curr)) && !$past(reg_we && reg_addr == 2'd2))
      |-> (stat_valid && stat_code == 8'h01));
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .reg_we(reg_we), .reg_addr(reg_addr),
  .mem_we(mem_we), .mem_addr(mem_addr), .stat_valid(stat_valid), .stat_code(stat_code),
  .curr(curr), .bound(bound)
);

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
  localparam int PW = 5;
  localparam int OW = 4;
  localparam int PSZ = 1 << OW;
  localparam int AW = PW + OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic [1:0] in_err = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [PW-1:0] reg_wdata = '0;
  logic [PW-1:0] reg_rdata;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic stat_valid;
  logic [7:0] stat_code;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] bmem [0:(1<<AW)-1];
  logic bound_hit = 1'b0;
  int m_pstart = 2, m_pstop = 10, m_curr = 2, m_bound = 9;

  always #2 clk = ~clk;

  rxr_ring_writer #(.PAGE_W(PW), .OFF_W(OW)) u_rxr_ring_writer (.*);

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      if (in_ready && int'(mem_addr[AW-1:OW]) == m_bound) bound_hit <= 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p + 1 == m_pstop) ? m_pstart : p + 1;
  endfunction

  function automatic int prv(input int p);
    return (p == m_pstart) ? m_pstop - 1 : p - 1;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = PW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic run_frame(input int L, input logic [1:0] e, input int gap, input int seed);
    int page, off, lastpg, ovf, code, exp_code, hcyc, got, pg2, of2, ok;
    page = m_curr; off = 4; ovf = 0; lastpg = page;
    for (int i = 0; i < L; i++) begin
      if (page == m_bound) begin ovf = 1; break; end
      lastpg = page;
      off++;
      if (off == PSZ) begin off = 0; page = nxt(page); end
    end
    bound_hit = 1'b0;
    for (int i = 0; i < L; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(seed + i); in_last = (i == L - 1);
      in_err = (i == L - 1) ? e : 2'b00;
      while (!in_ready) @(negedge clk);
    end
    hcyc = 0; code = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_err = 2'b00;
      if (stat_valid) begin code = int'(stat_code); break; end
      if (!in_ready) hcyc++;
    end
    exp_code = ovf ? 8 : (e != 0) ? int'(e) * 2 : 1;
    check("R6 status code", code, exp_code);
    check("R9 header stall cycles", hcyc, (exp_code == 1) ? 4 : 0);
    check("R7 boundary page untouched", int'(bound_hit), 0);
    if (exp_code == 1) begin
      check("R3 header status", int'(bmem[AW'(m_curr * PSZ)]), 1);
      check("R3 header next page", int'(bmem[AW'(m_curr * PSZ + 1)]), nxt(lastpg));
      check("R4 header length", int'(bmem[AW'(m_curr * PSZ + 2)]) +
            256 * int'(bmem[AW'(m_curr * PSZ + 3)]), L);
      pg2 = m_curr; of2 = 4; ok = 1;
      for (int i = 0; i < L; i++) begin
        if (bmem[AW'(pg2 * PSZ + of2)] != 8'(seed + i)) ok = 0;
        of2++;
        if (of2 == PSZ) begin of2 = 0; pg2 = nxt(pg2); end
      end
      check("R2 frame data placement", ok, 1);
      m_curr = nxt(lastpg);
    end
    rd_reg(2'd2, got);
    check("R5 current page", got, m_curr);
  endtask

  initial begin
    int v;
    for (int i = 0; i < (1 << AW); i++) bmem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", int'(in_ready), 1);
    check("R8 no status after reset", int'(stat_valid), 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      check("R1 reset value", v, 0);
    end
    wr_reg(2'd0, m_pstart); wr_reg(2'd1, m_pstop);
    wr_reg(2'd2, m_curr);   wr_reg(2'd3, m_bound);
    rd_reg(2'd0, v); check("R1 start readback", v, m_pstart);
    rd_reg(2'd1, v); check("R1 stop readback", v, m_pstop);
    rd_reg(2'd3, v); check("R1 bound readback", v, m_bound);
    // sweep lengths with the host consuming everything after each frame
    for (int L = 1; L <= 44; L++) begin
      logic [1:0] e;
      e = (L % 7 == 3) ? 2'b01 : (L % 11 == 5) ? 2'b10 : (L % 13 == 6) ? 2'b11 : 2'b00;
      run_frame(L, e, L % 3, L * 17);
      m_bound = prv(m_curr);
      wr_reg(2'd3, m_bound);
    end
    // freeze the boundary and fill the ring until it overflows (R7)
    for (int n = 0; n < 6; n++) run_frame(24, 2'b00, n % 2, 100 + n);
    run_frame(1, 2'b00, 0, 7);
    // free the ring and confirm recovery
    m_bound = prv(m_curr);
    wr_reg(2'd3, m_bound);
    run_frame(30, 2'b00, 1, 55);
    run_frame(12, 2'b00, 0, 66);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule